// File: doc/BRIEF.md
# Generation-Bit Event Ring Reader

This block drains a ring of 32-bit notification words that another agent writes into shared memory. The ring has no producer pointer. Each slot instead carries a generation flag in its top bit, and the writer inverts that flag every time it laps the ring. The reader keeps a slot index and the generation value it treats as stale. On each dequeue request it issues one memory read for the slot at the index. It byte-swaps the big-endian word and compares the flag with its stale value. It then returns either the 31-bit payload or zero, meaning nothing is pending.

A consumer pulses a request and waits for a one-cycle response strobe. Payloads that carry the reserved inter-processor code are replaced by a vector that is configured on an input pin, and they are flagged on a separate output. Only one memory read is ever in flight. The memory answers with a valid strobe after any latency, and the response follows one cycle after that strobe.

Top module: `evq_reader`

## Requirements
- R1: After reset, `rsp_valid` and `mem_rd_en` are 0. The slot index and the stale-generation value are both 0, so the first read goes to slot 0 and a slot whose top flag is 0 counts as empty.
- R2: A request seen while the block is idle raises `mem_rd_en` for exactly one cycle, starting the cycle after the request. `mem_rd_addr` carries the current slot index.
- R3: Each memory word is stored big-endian. Byte 0 (bits 7:0 of `mem_rd_data`) holds bits 31:24 of the logical entry. The logical bit 31 is the generation flag and logical bits 30:0 are the payload.
- R4: If the generation flag equals the stale value, the response payload is 0 and `rsp_is_ipi` is 0. Neither the index nor the stale value changes, so the next read uses the same slot.
- R5: If the generation flag differs from the stale value, the response carries logical bits 30:0 and the index advances by one.
- R6: The index counts modulo 2^IDX_W (1024 slots by default). When it wraps from the last slot to 0, the stale value inverts. From then on, slots written with flag 0 are new and slots with flag 1 are empty.
- R7: A new entry whose payload equals 2^24 is returned as the value on `ipi_vector`, with `rsp_is_ipi` = 1. Any other payload gives `rsp_is_ipi` = 0.
- R8: `rsp_valid` rises exactly one cycle after the `mem_rd_valid` that answers the outstanding read, and it lasts one cycle.
- R9: Requests that arrive while a read is outstanding are ignored. No second memory read is issued, and the index moves at most once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deq_req | input | 1 | Dequeue request |
| ipi_vector | input | 31 | Replacement value for the inter-processor code |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | IDX_W | Slot index to read |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | 32 | Raw big-endian slot word |
| rsp_valid | output | 1 | Response strobe |
| rsp_payload | output | 31 | Dequeued payload, 0 when empty |
| rsp_is_ipi | output | 1 | Response is the inter-processor event |

## Verification
A request taken at one clock edge puts `mem_rd_en` out at that edge. The bench memory model returns data one edge later, and the response strobe follows one edge after that, so the result is due three edges after the request. Inputs change on the falling edge, and the bench counts falling edges from the request. It checks that the strobe appears on the third one, and it captures the read address while `mem_rd_en` is high. The effect of each dequeue on the index is checked at the ports, through the address of the next read.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned PAYLOAD_W = 31;
  localparam logic [PAYLOAD_W-1:0] IPI_CODE = 31'(32'h0100_0000);

  // Memory byte 0 holds the most significant logical byte.
  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // A slot is new when its generation flag differs from the stale value.
  function automatic logic slot_is_new(input logic [31:0] logical, input logic stale);
    return logical[31] != stale;
  endfunction
endpackage

// File: rtl/evq_fetch_ctrl.sv
module evq_fetch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic deq_req,
  input  logic mem_rd_valid,
  output logic rd_en,
  output logic commit,
  output logic rsp_valid
);
  logic busy_q;
  logic rd_en_q;
  logic rsp_q;
  logic accept;

  assign accept = deq_req && !busy_q;
  assign commit = busy_q && mem_rd_valid;
  assign rd_en  = rd_en_q;
  assign rsp_valid = rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_en_q <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      rd_en_q <= accept;
      rsp_q   <= commit;
      if (accept) busy_q <= 1'b1;
      else if (commit) busy_q <= 1'b0;
    end
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R9
  AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> rsp_valid); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_REQ_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_en); // R2
endmodule

// File: rtl/evq_ring_ptr.sv
module evq_ring_ptr #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             entry_new,
  output logic [IDX_W-1:0] idx,
  output logic             stale
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q;
  logic             stale_q;
  logic             advance;
  logic             wrap;

  assign advance = commit && entry_new;
  assign wrap    = advance && (idx_q == LAST_IDX);
  assign idx     = idx_q;
  assign stale   = stale_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      stale_q <= 1'b0;
    end else if (advance) begin
      idx_q <= idx_q + 1'b1;
      if (wrap) stale_q <= ~stale_q;
    end
  end

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !entry_new) |=> ($stable(idx_q) && $stable(stale_q))); // R4
  AST_WRAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (idx_q == '0 && stale_q != $past(stale_q))); // R6
  AST_NO_FLIP_MIDRING: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && idx_q != LAST_IDX) |=> $stable(stale_q)); // R6
endmodule

// File: rtl/evq_decode.sv
module evq_decode
  import evq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [31:0]          raw_word,
  input  logic                 stale,
  input  logic [PAYLOAD_W-1:0] ipi_vector,
  output logic                 entry_new,
  output logic [PAYLOAD_W-1:0] payload,
  output logic                 is_ipi
);
  logic [31:0]          logical;
  logic [PAYLOAD_W-1:0] body;
  logic                 hit_ipi;

  assign logical   = swap_bytes(raw_word);
  assign entry_new = slot_is_new(logical, stale);
  assign body      = entry_new ? logical[PAYLOAD_W-1:0] : '0;
  assign hit_ipi   = entry_new && (body == IPI_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      payload <= '0;
      is_ipi  <= 1'b0;
    end else if (commit) begin
      payload <= hit_ipi ? ipi_vector : body;
      is_ipi  <= hit_ipi;
    end
  end

  AST_IPI_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && hit_ipi) |=> is_ipi); // R7
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !entry_new) |=> (payload == '0 && !is_ipi)); // R4
endmodule

// File: rtl/evq_reader.sv
module evq_reader
  import evq_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 deq_req,
  input  logic [PAYLOAD_W-1:0] ipi_vector,
  output logic                 mem_rd_en,
  output logic [IDX_W-1:0]     mem_rd_addr,
  input  logic                 mem_rd_valid,
  input  logic [31:0]          mem_rd_data,
  output logic                 rsp_valid,
  output logic [PAYLOAD_W-1:0] rsp_payload,
  output logic                 rsp_is_ipi
);
  logic commit;
  logic entry_new;
  logic stale;

  evq_fetch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .deq_req(deq_req), .mem_rd_valid(mem_rd_valid),
    .rd_en(mem_rd_en), .commit(commit), .rsp_valid(rsp_valid)
  );

  evq_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .entry_new(entry_new),
    .idx(mem_rd_addr), .stale(stale)
  );

  evq_decode u_dec (
    .clk(clk), .rst_n(rst_n), .commit(commit), .raw_word(mem_rd_data),
    .stale(stale), .ipi_vector(ipi_vector), .entry_new(entry_new),
    .payload(rsp_payload), .is_ipi(rsp_is_ipi)
  );

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> $stable(mem_rd_addr)); // R2
endmodule

// File: tb/evq_reader_tb.sv
module evq_reader_tb;
  localparam int IDX_W = 10;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic deq_req = 1'b0;
  logic [30:0] ipi_vector = 31'h55;
  logic mem_rd_en;
  logic [IDX_W-1:0] mem_rd_addr;
  logic mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic rsp_valid;
  logic [30:0] rsp_payload;
  logic rsp_is_ipi;

  logic [31:0] mem [N];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  int prod_idx = 0;
  bit prod_gen = 1'b1;

  always #10 clk = ~clk;

  evq_reader #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .deq_req(deq_req), .ipi_vector(ipi_vector),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_payload(rsp_payload),
    .rsp_is_ipi(rsp_is_ipi)
  );

  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
  end

  function automatic logic [31:0] be_word(input bit gen, input logic [30:0] p);
    logic [31:0] l;
    l = {gen, p};
    return {l[7:0], l[15:8], l[23:16], l[31:24]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic produce(input logic [30:0] p);
    mem[prod_idx] = be_word(prod_gen, p);
    prod_idx = (prod_idx + 1) % N;
    if (prod_idx == 0) prod_gen = ~prod_gen;
  endtask

  task automatic deq(input int hold, output logic [30:0] pay, output logic ipi,
                     output int addr, output int lat, output int reads);
    @(negedge clk) deq_req = 1'b1;
    lat = 0; reads = 0; addr = -1;
    do begin
      @(negedge clk);
      lat++;
      if (lat >= hold) deq_req = 1'b0;
      if (mem_rd_en) begin reads++; addr = int'(mem_rd_addr); end
    end while (!rsp_valid && lat < 20);
    pay = rsp_payload; ipi = rsp_is_ipi;
    @(negedge clk);
    check("R8 strobe one cycle", 32'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 mem_rd_en", 32'(mem_rd_en), 0);
    check("R1 addr", 32'(mem_rd_addr), 0);
  endtask

  task automatic t_empty();
    logic [30:0] p; logic i; int a, l, r;
    deq(1, p, i, a, l, r);
    check("R4 empty payload", 32'(p), 0);
    check("R4 empty ipi", 32'(i), 0);
    check("R2 read addr", a, 0);
    check("R8 latency", l, 3);
    check("R2 one read", r, 1);
    deq(1, p, i, a, l, r);
    check("R4 index held", a, 0);
  endtask

  task automatic t_data();
    logic [30:0] p; logic i; int a, l, r;
    produce(31'h0A0B0C0D);
    produce(31'h0000_0001);
    deq(1, p, i, a, l, r);
    check("R3 R5 payload", 32'(p), 32'h0A0B0C0D);
    check("R5 addr", a, 0);
    deq(1, p, i, a, l, r);
    check("R5 payload2", 32'(p), 1);
    check("R5 advanced", a, 1);
    deq(1, p, i, a, l, r);
    check("R4 empty after", 32'(p), 0);
    check("R5 addr2", a, 2);
  endtask

  task automatic t_ipi();
    logic [30:0] p; logic i; int a, l, r;
    produce(31'h0100_0000);
    produce(31'h0100_0001);
    deq(1, p, i, a, l, r);
    check("R7 remap", 32'(p), 32'h55);
    check("R7 flag", 32'(i), 1);
    deq(1, p, i, a, l, r);
    check("R7 near code", 32'(p), 32'h0100_0001);
    check("R7 no flag", 32'(i), 0);
  endtask

  task automatic t_busy();
    logic [30:0] p; logic i; int a, l, r;
    produce(31'h77);
    produce(31'h78);
    deq(3, p, i, a, l, r);
    check("R9 single read", r, 1);
    check("R9 payload", 32'(p), 32'h77);
    deq(1, p, i, a, l, r);
    check("R9 moved once", 32'(p), 32'h78);
  endtask

  task automatic t_wrap();
    logic [30:0] p; logic i; int a, l, r;
    int errs = 0;
    while (prod_idx != 0) begin
      produce(31'(prod_idx + 31'h100));
      deq(1, p, i, a, l, r);
      if (p !== 31'(a + 31'h100)) errs++;
    end
    check("R6 fill to end", errs, 0);
    deq(1, p, i, a, l, r);
    check("R6 wrapped addr", a, 0);
    check("R6 old gen empty", 32'(p), 0);
    produce(31'h2222);
    deq(1, p, i, a, l, r);
    check("R6 new gen valid", 32'(p), 32'h2222);
    check("R6 addr after", a, 0);
    deq(1, p, i, a, l, r);
    check("R6 next slot stale", 32'(p), 0);
    check("R6 next addr", a, 1);
  endtask

  initial begin
    for (int k = 0; k < N; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty();
    t_data();
    t_ipi();
    t_busy();
    t_wrap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule